// File: doc/BRIEF.md
# Dual-Group Peak Limiter with Shared Gain

This block limits the level of a multichannel audio path frame by frame. Every channel is assigned by a two-bit code to one of two limiter groups (A or B) or to no group. At each sample-frame strobe, each group takes the largest magnitude among the input samples of its member channels. It compares that one value with an attack threshold and a release threshold, and moves the group's gain down or up by a programmable step. All members of a group are scaled by the same gain. Channels outside both groups pass at unity gain.

Input samples carry a few bits of headroom above output full scale, because digital gain may already have been applied upstream. After scaling, each channel is saturated to the signed output range. A small write-only register file holds the following settings for each group: the attack and release rate codes, the coarse threshold codes, and the two fine threshold override registers. A mode pin selects anticlip behaviour or night (range reduction) behaviour.

Top module: `peak_limiter_dual`

## Requirements
- R1: After synchronous reset, both gains are unity (0x8000, unsigned Q1.15), `samples_out` is zero and `out_valid` is low. The rate registers return to 0x6A and the coarse threshold registers to 0x69. The fine override registers return to 0x00.
- R2: Channel c is assigned by `ch_map[2c+1:2c]`: 01 selects group A, 10 selects group B, and 00 or 11 selects no group. A channel in no group is scaled by unity gain. Every output is saturated to the range -32768..32767.
- R3: The peak of a group is the largest absolute input value among that group's member channels in the current frame. The gain derived from it is applied to every member.
- R4: One cycle after a `frame_valid` strobe, `out_valid` is high for one cycle. Each output equals sat(floor(x*g/32768)), where g is the channel's gain before the update made by this frame.
- R5: If the group peak is strictly greater than the attack threshold, the gain falls by the attack step. It is clamped at 0.
- R6: A release adds the release step to the gain. The gain never exceeds unity.
- R7: The step for a 4-bit rate code k is 2^k. In each rate register, bits [7:4] hold the attack code and bits [3:0] hold the release code.
- R8: The coarse threshold for a code n is (n+1)*2048. In each coarse threshold register, bits [7:4] hold the attack code and bits [3:0] hold the release code.
- R9: When bit 7 of a fine override register is 1, its threshold is (e+1)*256, where e is the register's bits [6:0]. When bit 7 is 0, the coarse code is used. Attack and release have separate override registers.
- R10: With `night_mode` low (anticlip), any frame that does not attack releases. With `night_mode` high, a frame releases only if the peak is below the release threshold. Otherwise the gain holds.
- R11: A gain changes only on a cycle where `frame_valid` is high.
- R12: Register addresses are as follows. 0 holds the A rates, 1 the A coarse thresholds, 2 the B rates and 3 the B coarse thresholds. 4 and 5 hold the A attack and release overrides. 6 and 7 hold the B attack and release overrides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | One-cycle strobe marking a new sample frame |
| samples_in | input | NCH*IW (72) | Signed input samples, channel c at [c*IW +: IW] |
| ch_map | input | 2*NCH (8) | Group assignment per channel |
| night_mode | input | 1 | 0 selects anticlip, 1 selects night |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| samples_out | output | NCH*DW (64) | Scaled, saturated output samples |
| out_valid | output | 1 | Output frame valid |
| gain_a | output | 16 | Current gain of group A |
| gain_b | output | 16 | Current gain of group B |

## Verification
The hardest state to reach is the night-mode hold. In this state the peak lies between the two thresholds and the gain is already below unity. At reset the release threshold sits above the attack threshold, so the hold band cannot be entered. The stimulus therefore first reprograms the coarse thresholds to open a wide band, then drives one over-threshold frame to pull the gain down, and only then presents an in-band peak. The fine overrides are then toggled on and off around that same input to show which threshold source is in force.

// File: rtl/peak_lim_pkg.sv
package peak_lim_pkg;

    localparam int GAIN_W = 16;
    localparam int FRAC   = GAIN_W - 1;
    localparam logic [GAIN_W-1:0] UNITY = 16'h8000;

    typedef enum logic [1:0] {
        GRP_NONE  = 2'b00,
        GRP_A     = 2'b01,
        GRP_B     = 2'b10,
        GRP_NONE2 = 2'b11
    } grp_e;

    typedef struct packed {
        logic [3:0] att_rate;
        logic [3:0] rel_rate;
        logic [3:0] att_code;
        logic [3:0] rel_code;
        logic [7:0] fine_att;
        logic [7:0] fine_rel;
    } lim_cfg_t;

    function automatic logic [GAIN_W:0] rate_step(input logic [3:0] code);
        return (GAIN_W+1)'(1) << code;
    endfunction

    function automatic logic [31:0] coarse_thr(input logic [3:0] code, input int dw);
        return (32'(code) + 32'd1) << (dw - 5);
    endfunction

    function automatic logic [31:0] fine_thr(input logic [6:0] code, input int dw);
        return (32'(code) + 32'd1) << (dw - 8);
    endfunction

    function automatic logic [31:0] pick_thr(input logic [7:0] fine, input logic [3:0] coarse,
                                             input int dw);
        return fine[7] ? fine_thr(fine[6:0], dw) : coarse_thr(coarse, dw);
    endfunction

endpackage

// File: rtl/lim_regs.sv
module lim_regs
    import peak_lim_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output lim_cfg_t   cfg_a,
    output lim_cfg_t   cfg_b
);
    localparam logic [7:0] RATE_RST = 8'h6A;
    localparam logic [7:0] THR_RST  = 8'h69;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_a <= '{att_rate: RATE_RST[7:4], rel_rate: RATE_RST[3:0],
                       att_code: THR_RST[7:4],  rel_code: THR_RST[3:0],
                       fine_att: 8'h00, fine_rel: 8'h00};
            cfg_b <= '{att_rate: RATE_RST[7:4], rel_rate: RATE_RST[3:0],
                       att_code: THR_RST[7:4],  rel_code: THR_RST[3:0],
                       fine_att: 8'h00, fine_rel: 8'h00};
        end else if (we) begin
            case (addr)
                3'd0: {cfg_a.att_rate, cfg_a.rel_rate} <= wdata;
                3'd1: {cfg_a.att_code, cfg_a.rel_code} <= wdata;
                3'd2: {cfg_b.att_rate, cfg_b.rel_rate} <= wdata;
                3'd3: {cfg_b.att_code, cfg_b.rel_code} <= wdata;
                3'd4: cfg_a.fine_att <= wdata;
                3'd5: cfg_a.fine_rel <= wdata;
                3'd6: cfg_b.fine_att <= wdata;
                default: cfg_b.fine_rel <= wdata;
            endcase
        end
    end

    // R1
    cfg_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ({cfg_a.att_rate, cfg_a.rel_rate} == RATE_RST &&
                        {cfg_b.att_code, cfg_b.rel_code} == THR_RST &&
                        cfg_a.fine_att == 8'h00 && cfg_b.fine_rel == 8'h00));
endmodule

// File: rtl/lim_gain.sv
module lim_gain
    import peak_lim_pkg::*;
#(
    parameter int   NCH = 4,
    parameter int   IW  = 18,
    parameter int   DW  = 16,
    parameter grp_e SEL = GRP_A
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_valid,
    input  logic                 night_mode,
    input  lim_cfg_t             cfg,
    input  logic signed [IW-1:0] samples [NCH],
    input  logic [1:0]           grp     [NCH],
    output logic [GAIN_W-1:0]    gain
);
    logic [IW-1:0]   mag [NCH];
    logic [IW-1:0]   peak;
    logic [31:0]     att_thr, rel_thr, peak_w;
    logic [GAIN_W:0] att_step, rel_step, raised;
    logic            do_attack, do_release;

    for (genvar i = 0; i < NCH; i++) begin : g_mag
        assign mag[i] = samples[i][IW-1] ? (~samples[i] + 1'b1) : samples[i];
    end

    always_comb begin
        peak = '0;
        for (int i = 0; i < NCH; i++) begin
            if (grp[i] == SEL && mag[i] > peak) peak = mag[i];
        end
    end

    assign peak_w     = 32'(peak);
    assign att_thr    = pick_thr(cfg.fine_att, cfg.att_code, DW);
    assign rel_thr    = pick_thr(cfg.fine_rel, cfg.rel_code, DW);
    assign att_step   = rate_step(cfg.att_rate);
    assign rel_step   = rate_step(cfg.rel_rate);
    assign raised     = {1'b0, gain} + rel_step;
    assign do_attack  = peak_w > att_thr;
    assign do_release = !do_attack && (!night_mode || peak_w < rel_thr);

    always_ff @(posedge clk) begin
        if (rst) begin
            gain <= UNITY;
        end else if (frame_valid) begin
            if (do_attack)
                gain <= ({1'b0, gain} > att_step) ? gain - att_step[GAIN_W-1:0] : '0;
            else if (do_release)
                gain <= (raised >= {1'b0, UNITY}) ? UNITY : raised[GAIN_W-1:0];
        end
    end

    // R5
    attack_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && peak_w > att_thr && gain != '0) |=> gain < $past(gain));
    // R6
    unity_cap_chk: assert property (@(posedge clk) disable iff (rst)
        gain <= UNITY);
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |=> $stable(gain));
    // R10
    night_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && night_mode && peak_w <= att_thr && peak_w >= rel_thr) |=> $stable(gain));
endmodule

// File: rtl/lim_chan.sv
module lim_chan
    import peak_lim_pkg::*;
#(
    parameter int IW = 18,
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_valid,
    input  logic signed [IW-1:0] sample,
    input  logic [GAIN_W-1:0]    gain,
    output logic signed [DW-1:0] y
);
    localparam int PW   = IW + GAIN_W + 1;
    localparam int MAXV = 2 ** (DW - 1) - 1;
    localparam logic signed [PW-1:0] HI    = PW'(MAXV);
    localparam logic signed [PW-1:0] LO    = -HI - 1;
    localparam logic signed [IW-1:0] IN_HI = IW'(MAXV);
    localparam logic signed [DW-1:0] Y_HI  = DW'(MAXV);
    localparam logic signed [DW-1:0] Y_LO  = -Y_HI - 1;

    logic signed [PW-1:0] prod, scaled;

    assign prod   = sample * $signed({1'b0, gain});
    assign scaled = prod >>> FRAC;

    always_ff @(posedge clk) begin
        if (rst)
            y <= '0;
        else if (frame_valid)
            y <= (scaled > HI) ? Y_HI : (scaled < LO) ? Y_LO : scaled[DW-1:0];
    end

    // R2
    sat_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && gain == UNITY && sample > IN_HI) |=> y == Y_HI);
    // R2
    sat_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && gain == UNITY && sample < -IN_HI - 1) |=> y == Y_LO);
endmodule

// File: rtl/peak_limiter_dual.sv
module peak_limiter_dual
    import peak_lim_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 16,
    parameter int HW  = 2,
    localparam int IW = DW + HW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_valid,
    input  logic [NCH*IW-1:0]     samples_in,
    input  logic [2*NCH-1:0]      ch_map,
    input  logic                  night_mode,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_addr,
    input  logic [7:0]            cfg_wdata,
    output logic [NCH*DW-1:0]     samples_out,
    output logic                  out_valid,
    output logic [GAIN_W-1:0]     gain_a,
    output logic [GAIN_W-1:0]     gain_b
);
    lim_cfg_t             cfg_a, cfg_b;
    logic signed [IW-1:0] smp [NCH];
    logic [1:0]           grp [NCH];

    lim_regs u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .cfg_a(cfg_a), .cfg_b(cfg_b)
    );

    lim_gain #(.NCH(NCH), .IW(IW), .DW(DW), .SEL(GRP_A)) u_gain_a (
        .clk(clk), .rst(rst), .frame_valid(frame_valid), .night_mode(night_mode),
        .cfg(cfg_a), .samples(smp), .grp(grp), .gain(gain_a)
    );

    lim_gain #(.NCH(NCH), .IW(IW), .DW(DW), .SEL(GRP_B)) u_gain_b (
        .clk(clk), .rst(rst), .frame_valid(frame_valid), .night_mode(night_mode),
        .cfg(cfg_b), .samples(smp), .grp(grp), .gain(gain_b)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [GAIN_W-1:0]    g_sel;
        logic signed [DW-1:0] y_c;

        assign smp[c] = samples_in[c*IW +: IW];
        assign grp[c] = ch_map[2*c +: 2];
        assign g_sel  = (grp[c] == GRP_A) ? gain_a :
                        (grp[c] == GRP_B) ? gain_b : UNITY;

        lim_chan #(.IW(IW), .DW(DW)) u_chan (
            .clk(clk), .rst(rst), .frame_valid(frame_valid),
            .sample(smp[c]), .gain(g_sel), .y(y_c)
        );
        assign samples_out[c*DW +: DW] = y_c;
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= frame_valid;
    end

    // R4
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> out_valid);
    // R4
    valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |=> !out_valid);
endmodule

// File: tb/peak_limiter_dual_bench.sv
`timescale 1ns/100ps
module peak_limiter_dual_bench;
    localparam int NCH = 4;
    localparam int DW  = 16;
    localparam int IW  = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_valid = 1'b0;
    logic [NCH*IW-1:0] samples_in = '0;
    logic [2*NCH-1:0]  ch_map = 8'b00_10_01_01;
    logic night_mode = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [NCH*DW-1:0] samples_out;
    logic out_valid;
    logic [15:0] gain_a, gain_b;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    peak_limiter_dual u_peak_limiter_dual (
        .clk(clk), .rst(rst), .frame_valid(frame_valid), .samples_in(samples_in),
        .ch_map(ch_map), .night_mode(night_mode), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .samples_out(samples_out), .out_valid(out_valid),
        .gain_a(gain_a), .gain_b(gain_b)
    );

    typedef struct packed {
        logic signed [17:0] s3, s2, s1, s0;
        logic signed [15:0] y3, y2, y1, y0;
        logic [15:0] ga, gb;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{18'sd40000, 18'sd100, -18'sd1000, 18'sd20000,
          16'sd32767, 16'sd100, -16'sd1000, 16'sd20000, 16'd32704, 16'd32768},
        '{-18'sd40000, -18'sd20000, 18'sd0, 18'sd16384,
          -16'sd32768, -16'sd20000, 16'sd0, 16'sd16352, 16'd32640, 16'd32704},
        '{18'sd0, 18'sd0, -18'sd16384, 18'sd0,
          16'sd0, 16'sd0, -16'sd16320, 16'sd0, 16'd32576, 16'd32768},
        '{18'sd0, 18'sd0, 18'sd0, 18'sd0,
          16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'd32768, 16'd32768}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int yout(input int c);
        return int'($signed(samples_out[c*DW +: DW]));
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic frame(input int s0, input int s1, input int s2, input int s3);
        @(negedge clk);
        samples_in = {IW'(s3), IW'(s2), IW'(s1), IW'(s0)};
        frame_valid = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1", "gain_a", gain_a, 32768);
        check("R1", "gain_b", gain_b, 32768);
        check("R1", "out_valid", out_valid, 0);
        check("R1", "y0", yout(0), 0);

        // Table: default registers (R1), R2 grouping and saturation, R3 shared gain,
        // R4 output math, R5 attack, R6 release with cap
        for (int i = 0; i < 4; i++) begin
            frame(VECS[i].s0, VECS[i].s1, VECS[i].s2, VECS[i].s3);
            check("R4", "out_valid", out_valid, 1);
            check("R3", "y0", yout(0), VECS[i].y0);
            check("R3", "y1", yout(1), VECS[i].y1);
            check("R4", "y2", yout(2), VECS[i].y2);
            check("R2", "y3", yout(3), VECS[i].y3);
            check("R5", "gain_a", gain_a, VECS[i].ga);
            check("R6", "gain_b", gain_b, VECS[i].gb);
        end
        @(negedge clk);
        check("R4", "out_valid drop", out_valid, 0);

        // R5 boundary: peak equal to threshold 14336 does not attack
        frame(14336, 0, 0, 0);
        check("R5", "gain_a at equal", gain_a, 32768);

        // R9 fine attack override at address 4 (R12): threshold (63+1)*256=16384
        wr(3'd4, 8'hBF);
        frame(15000, 0, 0, 0);
        check("R9", "fine att on", gain_a, 32768);
        wr(3'd4, 8'h3F);
        frame(15000, 0, 0, 0);
        check("R8", "coarse att back", gain_a, 32704);
        frame(0, 0, 0, 0);
        check("R6", "recover", gain_a, 32768);

        // R10 night hold: coarse att code F (32768), rel code 3 (8192) via addr 1 (R12)
        wr(3'd1, 8'hF3);
        night_mode = 1'b1;
        frame(40000, 0, 0, 0);
        check("R2", "y0 sat", yout(0), 32767);
        check("R8", "attack over F", gain_a, 32704);
        frame(20000, 0, 0, 0);
        check("R4", "y0 scaled", yout(0), 19960);
        check("R10", "night hold", gain_a, 32704);
        // R9 fine release override at address 5: (127+1)*256 = 32768
        wr(3'd5, 8'hFF);
        frame(20000, 0, 0, 0);
        check("R9", "fine rel on", gain_a, 32768);
        frame(40000, 0, 0, 0);
        wr(3'd5, 8'h00);
        night_mode = 1'b0;
        frame(20000, 0, 0, 0);
        check("R10", "anticlip release", gain_a, 32768);

        // R7 rate codes via addr 0 (R12): attack 2^15, release 2^0
        wr(3'd0, 8'hF0);
        frame(40000, 0, 0, 0);
        check("R7", "attack to floor", gain_a, 0);
        frame(1000, 0, 0, 0);
        check("R5", "y0 zero gain", yout(0), 0);
        check("R7", "release step 1", gain_a, 1);
        frame(1000, 0, 0, 0);
        check("R7", "release step 2", gain_a, 2);

        // R11 gain stays without a frame strobe
        repeat (10) @(negedge clk);
        check("R11", "idle hold", gain_a, 2);

        // R3 group B peak over ch2 and ch3; ch_map code 11 is no group for ch1 (R2)
        ch_map = 8'b10_10_11_01;
        frame(0, 40000, 100, -20000);
        check("R2", "y1 code 11", yout(1), 32767);
        check("R3", "gain_b from ch3", gain_b, 32704);
        frame(0, 0, 16384, 0);
        check("R3", "y2 shared", yout(2), 16352);
        check("R3", "gain_b second", gain_b, 32640);

        // R1 register reset values restored
        do_reset();
        ch_map = 8'b00_10_01_01;
        check("R1", "gain_b reset", gain_b, 32768);
        check("R1", "out_valid reset", out_valid, 0);
        frame(15000, 0, 0, 0);
        check("R1", "defaults 0x69/0x6A", gain_a, 32704);

        finish_up();
    end
endmodule